// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial-flash command at a time from three 32-bit registers on a simple synchronous register bus. Software first loads a command word, which holds a command byte and a 24-bit flash address. It may also load a data word. It then writes the control register with two byte counts, a clock-select field and a start bit. The block selects the flash device and clocks out the command, the address bytes and any write-data bytes in SPI mode 0. It then clocks in any reply bytes, packs them into the data register and releases the device. Software polls the busy flag in the control register to learn when the command has finished.

The sequencer has four states:
- `ST_IDLE`: the device is deselected and the clock is low.
- `ST_SHIFT_LO`: the select line is low, the clock is low and the current bit is on the output line. This state is held for one half-period before every rising edge, including the first one.
- `ST_SHIFT_HI`: the clock is high and the input line has been sampled.
- `ST_DESELECT`: the select line is high again for one half-period.

The transitions are:
- start: `ST_IDLE` to `ST_SHIFT_LO`.
- rise: `ST_SHIFT_LO` to `ST_SHIFT_HI` on a half-period tick, sampling the input line.
- next bit: `ST_SHIFT_HI` to `ST_SHIFT_LO` on a tick when bits remain.
- last bit: `ST_SHIFT_HI` to `ST_DESELECT` on a tick after the final bit.
- finish: `ST_DESELECT` to `ST_IDLE` on a tick. This clears busy and updates the data register.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, all three registers read 0, busy is 0, the select line is high and the clock is low.
- R2: The control register is at offset 0x0 and the command register at 0x4. The data register is at 0x8. The control register holds the transmit count in bits [3:0] and the receive count in bits [7:4]. Bit 8 is the start strobe and always reads 0. Bit 16 is busy, bits [18:17] are the size field and bits [25:24] are the clock select. The command and data registers read back what was written.
- R3: A control write with bit 8 set and a non-zero byte total makes busy read 1 from the next cycle. Busy stays 1 until the transaction is complete.
- R4: Transmitted bytes go out in this order: the command byte (command register [7:0]), then address bytes [31:24], [23:16] and [15:8] of the command register, then data register bytes [7:0], [15:8], [23:16] and [31:24]. Every byte goes out MSB first. Any position beyond the eighth transmits 0x00.
- R5: The bus uses SPI mode 0. The clock idles low, the output bit is stable while the clock is high, and the input line is sampled on the rising edge. The clock toggles only while the select line is low.
- R6: Reply bytes follow the transmitted bytes. Reply byte k goes to data bits [8k+7:8k] for k < 4, and data bytes at or above the receive count read 0. With a receive count of 0, the data register is unchanged.
- R7: A clock-select value s gives an SCLK period of 2^(s+1) system clocks (divide by 2, 4, 8 or 16).
- R8: The select line goes low one half-period before the first rising edge. It returns high at least one half-period before busy clears.
- R9: While busy, writes to any register are ignored, including a second start.
- R10: A start with both counts 0 starts nothing: busy stays 0 and no clock edge occurs.
- R11: The size field is stored and read back but has no effect on the serial traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| spi_cs_n | output | 1 | Active-low flash select |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions check the following on every cycle:
- the clock toggles only while the device is selected;
- the output bit stays stable while the clock is high;
- busy never falls while the select line is still low;
- an accepted start raises busy;
- register state stays frozen under writes issued while busy;
- half-period ticks never come back to back at slow clock selects;
- a one-byte reply leaves the upper data bytes at zero.

Only the directed scenarios can show:
- the exact byte order of commands, addresses and write data;
- the packing of replies into the data register;
- the measured SCLK period, lead time and release gap for each clock select;
- the no-op zero-count start.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    localparam int unsigned REG_W     = 32;
    localparam int unsigned CNT_W     = 4;
    localparam int unsigned SEL_W     = 2;
    localparam int unsigned SIZE_W    = 2;
    localparam int unsigned FRAME_W   = 64;
    localparam int unsigned BIT_W     = CNT_W + 4;

    localparam int unsigned OFS_CTRL  = 0;
    localparam int unsigned OFS_CMD   = 4;
    localparam int unsigned OFS_DATA  = 8;

    localparam int unsigned CTL_TX_LSB   = 0;
    localparam int unsigned CTL_RX_LSB   = 4;
    localparam int unsigned CTL_GO_BIT   = 8;
    localparam int unsigned CTL_BUSY_BIT = 16;
    localparam int unsigned CTL_SIZE_LSB = 17;
    localparam int unsigned CTL_CLK_LSB  = 24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT_LO,
        ST_SHIFT_HI,
        ST_DESELECT
    } eng_state_e;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned CNT_W = 1 << SEL_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = (CNT_W'(1) << sel) - CNT_W'(1);
        tick  = run && (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run || tick)  cnt_q <= '0;
        else                    cnt_q <= cnt_q + CNT_W'(1);
    end

    // R7: with a divide of 4 or more, ticks are never adjacent
    p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != '0) |=> !tick);
endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
    import spi_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [REG_W-1:0] cmd_word,
    input  logic [REG_W-1:0] data_word,
    input  logic             tick,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    output logic [REG_W-1:0] rx_word
);
    eng_state_e          state_q;
    logic [FRAME_W-1:0]  frame_q;
    logic [BIT_W-1:0]    bit_q, last_q, txbits_q, rel;
    logic [BIT_W-1:0]    total;
    logic [REG_W-1:0]    rx_q;
    logic                cap;
    logic [4:0]          rx_idx;

    always_comb begin
        total  = BIT_W'(tx_cnt) + BIT_W'(rx_cnt);
        rel    = bit_q - txbits_q;
        cap    = (bit_q >= txbits_q) && (rel[BIT_W-1:5] == '0);
        rx_idx = {rel[4:3], ~rel[2:0]};
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            frame_q  <= '0;
            bit_q    <= '0;
            last_q   <= '0;
            txbits_q <= '0;
            rx_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q  <= ST_SHIFT_LO;
                    frame_q  <= {cmd_word[7:0], cmd_word[31:24], cmd_word[23:16],
                                 cmd_word[15:8], data_word[7:0], data_word[15:8],
                                 data_word[23:16], data_word[31:24]};
                    bit_q    <= '0;
                    last_q   <= (total << 3) - BIT_W'(1);
                    txbits_q <= BIT_W'(tx_cnt) << 3;
                    rx_q     <= '0;
                end
                ST_SHIFT_LO: if (tick) begin
                    state_q <= ST_SHIFT_HI;
                    if (cap) rx_q[rx_idx] <= miso;
                end
                ST_SHIFT_HI: if (tick) begin
                    if (bit_q == last_q) begin
                        state_q <= ST_DESELECT;
                    end else begin
                        state_q <= ST_SHIFT_LO;
                        bit_q   <= bit_q + BIT_W'(1);
                        frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                    end
                end
                ST_DESELECT: if (tick) state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        cs_n = 1'b1;
        sclk = 1'b0;
        mosi = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_SHIFT_LO: begin cs_n = 1'b0; mosi = frame_q[FRAME_W-1]; end
            ST_SHIFT_HI: begin cs_n = 1'b0; sclk = 1'b1; mosi = frame_q[FRAME_W-1]; end
            ST_DESELECT: ;
        endcase
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DESELECT) && tick;
        rx_word = rx_q;
    end

    p_sclk_framed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);
    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    p_release_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cs_n));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_eng_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic [CNT_W-1:0]  tx_q, rx_q;
    logic [SIZE_W-1:0] size_q;
    logic [SEL_W-1:0]  clk_q;
    logic [REG_W-1:0]  cmd_q, dat_q, rx_word, rd_ctrl;
    logic              busy, done, tick, wr_ok, sel_ctrl, sel_cmd, sel_data, start_go;
    logic [CNT_W-1:0]  w_tx, w_rx;

    always_comb begin
        sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
        sel_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
        sel_data = (bus_addr == ADDR_W'(OFS_DATA));
        wr_ok    = bus_wr && !busy;
        w_tx     = bus_wdata[CTL_TX_LSB +: CNT_W];
        w_rx     = bus_wdata[CTL_RX_LSB +: CNT_W];
        start_go = wr_ok && sel_ctrl && bus_wdata[CTL_GO_BIT] &&
                   ((w_tx != '0) || (w_rx != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            rx_q   <= '0;
            size_q <= '0;
            clk_q  <= '0;
            cmd_q  <= '0;
            dat_q  <= '0;
        end else begin
            if (wr_ok && sel_ctrl) begin
                tx_q   <= w_tx;
                rx_q   <= w_rx;
                size_q <= bus_wdata[CTL_SIZE_LSB +: SIZE_W];
                clk_q  <= bus_wdata[CTL_CLK_LSB +: SEL_W];
            end
            if (wr_ok && sel_cmd) cmd_q <= bus_wdata;
            if (wr_ok && sel_data) dat_q <= bus_wdata;
            else if (done && (rx_q != '0)) dat_q <= rx_word;
        end
    end

    always_comb begin
        rd_ctrl = '0;
        rd_ctrl[CTL_TX_LSB +: CNT_W]    = tx_q;
        rd_ctrl[CTL_RX_LSB +: CNT_W]    = rx_q;
        rd_ctrl[CTL_BUSY_BIT]           = busy;
        rd_ctrl[CTL_SIZE_LSB +: SIZE_W] = size_q;
        rd_ctrl[CTL_CLK_LSB +: SEL_W]   = clk_q;
        if (sel_ctrl)      bus_rdata = rd_ctrl;
        else if (sel_cmd)  bus_rdata = cmd_q;
        else if (sel_data) bus_rdata = dat_q;
        else               bus_rdata = '0;
    end

    spi_half_tick #(.SEL_W(SEL_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .sel(clk_q), .tick(tick)
    );

    spi_seq_fsm u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_go),
        .tx_cnt(w_tx), .rx_cnt(w_rx),
        .cmd_word(cmd_q), .data_word(dat_q),
        .tick(tick), .miso(spi_miso),
        .busy(busy), .done(done),
        .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
        .rx_word(rx_word)
    );

    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |=> busy);
    p_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr) |=> ($stable(cmd_q) && $stable(tx_q) && $stable(rx_q) &&
                              $stable(clk_q) && $stable(size_q)));
    p_rx_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_q == CNT_W'(1)) |=> (dat_q[31:8] == '0));
endmodule

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_cs_n, spi_sclk, spi_mosi, spi_miso;

    int tests_run = 0;
    int tests_failed = 0;

    logic [127:0] mon_bits;
    int           mon_cnt;
    logic [127:0] reply_q;
    time          t_cs_fall, t_cs_rise, t_first_rise, t_prev_rise, t_period, t_idle;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // flash-side responder and monitor
    assign spi_miso = reply_q[127];
    always @(posedge spi_sclk) begin
        if (mon_cnt == 0) t_first_rise = $time;
        else t_period = $time - t_prev_rise;
        t_prev_rise = $time;
        mon_bits = {mon_bits[126:0], spi_mosi};
        mon_cnt++;
    end
    always @(negedge spi_sclk) reply_q = {reply_q[126:0], 1'b0};
    always @(negedge spi_cs_n) t_cs_fall = $time;
    always @(posedge spi_cs_n) t_cs_rise = $time;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            bus_read(4'h0, v);
            if (!v[16]) begin
                t_idle = $time;
                return;
            end
        end
        chk("R3 busy never cleared", 1, 0);
    endtask

    task automatic mon_clear(input logic [127:0] reply);
        mon_bits = '0; mon_cnt = 0; reply_q = reply;
    endtask

    function automatic logic [31:0] ctl(input int tx, input int rx, input int sel,
                                        input int sz, input bit go);
        logic [31:0] v = '0;
        v[3:0] = 4'(tx); v[7:4] = 4'(rx); v[8] = go;
        v[18:17] = 2'(sz); v[25:24] = 2'(sel);
        return v;
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        bus_read(4'h0, v); chk("R1 ctrl after reset", v, 0);
        bus_read(4'h4, v); chk("R1 cmd after reset", v, 0);
        bus_read(4'h8, v); chk("R1 data after reset", v, 0);
        chk("R1 idle pins", {spi_cs_n, spi_sclk}, 2'b10);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        mon_clear('0);
        bus_write(4'h0, ctl(5, 3, 2, 3, 0));
        bus_read(4'h0, v); chk("R2 R11 ctrl readback", v, 32'h0206_0035);
        bus_write(4'h4, 32'h1234_56AB);
        bus_read(4'h4, v); chk("R2 cmd readback", v, 32'h1234_56AB);
        bus_write(4'h8, 32'hDEAD_BEEF);
        bus_read(4'h8, v); chk("R2 data readback", v, 32'hDEAD_BEEF);
        chk("R2 no transfer without start", mon_cnt, 0);
    endtask

    task automatic t_single_byte();
        logic [31:0] v;
        mon_clear('0);
        bus_write(4'h4, 32'h0000_0006);
        bus_write(4'h0, ctl(1, 0, 0, 0, 1));
        @(negedge clk); bus_read(4'h0, v);
        chk("R3 busy after start", v[16], 1);
        chk("R2 start bit reads 0", v[8], 0);
        wait_idle();
        chk("R4 one-byte command", mon_bits[7:0], 8'h06);
        chk("R5 eight clocks", mon_cnt, 8);
        chk("R5 clock low when idle", spi_sclk, 0);
    endtask

    task automatic t_erase_and_program();
        mon_clear('0);
        bus_write(4'h4, 32'h1234_56D8);
        bus_write(4'h0, ctl(4, 0, 1, 0, 1));
        wait_idle();
        chk("R4 command plus address", mon_bits[31:0], 32'hD812_3456);
        chk("R4 address bit count", mon_cnt, 32);
        mon_clear('0);
        bus_write(4'h4, 32'h0001_FF02);
        bus_write(4'h8, 32'hA1B2_C3D4);
        bus_write(4'h0, ctl(8, 0, 0, 3, 1));
        wait_idle();
        chk("R4 R11 full program frame", mon_bits[63:0], 64'h0200_01FF_D4C3_B2A1);
        mon_clear('0);
        bus_write(4'h0, ctl(6, 0, 0, 0, 1));
        wait_idle();
        chk("R4 partial program frame", mon_bits[47:0], 48'h0200_01FF_D4C3);
        mon_clear('0);
        bus_write(4'h0, ctl(9, 0, 0, 0, 1));
        wait_idle();
        chk("R4 byte past eighth is zero", mon_bits[71:0], 72'h0200_01FF_D4C3_B2A1_00);
    endtask

    task automatic t_replies();
        logic [31:0] v;
        bus_write(4'h8, 32'hFFFF_FFFF);
        mon_clear({32'h0, 8'h15, 88'h0});
        bus_write(4'h4, 32'h0000_00AB);
        bus_write(4'h0, ctl(4, 1, 0, 0, 1));
        wait_idle();
        bus_read(4'h8, v); chk("R6 one reply byte masked", v, 32'h0000_0015);
        mon_clear({32'h0, 32'h1122_3344, 64'h0});
        bus_write(4'h4, 32'h0000_1003);
        bus_write(4'h0, ctl(4, 4, 1, 0, 1));
        wait_idle();
        bus_read(4'h8, v); chk("R6 four reply bytes", v, 32'h4433_2211);
        chk("R5 R6 total clocks", mon_cnt, 64);
        mon_clear({32'h0, 32'h5566_7788, 64'h0});
        bus_write(4'h0, ctl(4, 2, 0, 0, 1));
        wait_idle();
        bus_read(4'h8, v); chk("R6 two reply bytes", v, 32'h0000_6655);
        bus_write(4'h8, 32'hCAFE_BABE);
        mon_clear({128{1'b1}});
        bus_write(4'h0, ctl(1, 0, 0, 0, 1));
        wait_idle();
        bus_read(4'h8, v); chk("R6 zero receive count keeps data", v, 32'hCAFE_BABE);
    endtask

    task automatic t_divider();
        for (int s = 0; s < 4; s++) begin
            time h;
            h = time'(1 << s) * CLK_PERIOD;
            mon_clear('0);
            bus_write(4'h4, 32'h0000_0005);
            bus_write(4'h0, ctl(1, 0, s, 0, 1));
            wait_idle();
            chk($sformatf("R7 period sel %0d", s), t_period, 2 * h);
            chk($sformatf("R8 lead sel %0d", s), t_first_rise - t_cs_fall, h);
            chk($sformatf("R8 release gap sel %0d", s), (t_idle - t_cs_rise) >= h, 1);
        end
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        bus_write(4'h8, 32'h0BAD_F00D);
        bus_write(4'h4, 32'h0000_009F);
        mon_clear('0);
        bus_write(4'h0, ctl(4, 0, 3, 0, 1));
        bus_write(4'h0, ctl(1, 0, 0, 0, 1));
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_write(4'h8, 32'h1111_1111);
        wait_idle();
        bus_read(4'h0, v); chk("R9 ctrl unchanged", v, 32'h0300_0004);
        bus_read(4'h4, v); chk("R9 cmd unchanged", v, 32'h0000_009F);
        bus_read(4'h8, v); chk("R9 data unchanged", v, 32'h0BAD_F00D);
        chk("R9 no second transfer", mon_cnt, 32);
    endtask

    task automatic t_zero_start();
        logic [31:0] v;
        mon_clear('0);
        bus_write(4'h0, ctl(0, 0, 0, 0, 1));
        @(negedge clk); bus_read(4'h0, v);
        chk("R10 busy stays low", v[16], 0);
        repeat (20) @(negedge clk);
        chk("R10 no clock edges", mon_cnt, 0);
        chk("R10 select stays high", spi_cs_n, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        tests_run++; tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        mon_clear('0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_regmap();
        t_single_byte();
        t_erase_and_program();
        t_replies();
        t_divider();
        t_busy_ignore();
        t_zero_start();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule